// File: doc/BRIEF.md
# Duplex/Triplex Discrepancy Scoring Unit

This block sits behind two or three functionally identical logic instances that are fed the same input vector. It compares their result words, raises an alert on any disagreement, and grades each instance with a discrepancy score increment. A downstream controller adds these increments to its own tallies and uses them to choose which instances to swap out. This unit does neither of those jobs.

There are two operating modes. In duplex mode the two instance results are compared directly. A match forwards the word as a validated output. A mismatch charges the same score increment to both instances, because the unit does not try to decide which one is wrong, and the caller must recompute that input. In triplex mode a bitwise two-of-three vote forms the output, and each instance is scored against that vote. The score metric is chosen per strobe. It is either the number of differing bit positions, or the absolute difference of the two words read as unsigned integers.

Top module: `dscore_unit`

## Requirements
- R1: Duplex match (mode=0, word_a equals word_b): one cycle after the strobe, out_valid=1, sys_out=word_a, fault_alert=0, and all three increments are 0. word_c has no effect.
- R2: Duplex mismatch (mode=0, word_a differs from word_b): one cycle after the strobe, fault_alert=1, out_valid=0, sys_out=0, inc_a=inc_b=metric(word_a, word_b), and inc_c=0 whatever word_c holds.
- R3: Triplex mode (mode=1): sys_out is the bitwise majority of the three words. A bit is 1 when at least two of the three instances have a 1 there.
- R4: Triplex mode: out_valid=1 exactly when at least two of the three words are equal. fault_alert=1 exactly when the three words are not all equal.
- R5: Triplex mode: each instance's increment is metric(its word, bitwise majority).
- R6: metric_sel=0 selects the Hamming metric. This is the count of bit positions where the two words differ, from 0 to W.
- R7: metric_sel=1 selects the bit-weight metric. This is |x - y| with both words treated as unsigned, up to 2^W - 1.
- R8: Outputs are registered and appear one cycle after in_valid. After a cycle with in_valid=0, out_valid, fault_alert and all increments are 0 and sys_out keeps its previous value.
- R9: While rst_n=0, all outputs are cleared to 0 on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Strobe: the instance words are valid this cycle |
| mode | input | 1 | 0 = duplex, 1 = triplex |
| metric_sel | input | 1 | 0 = Hamming, 1 = bit-weight |
| word_a | input | W | Result of instance A |
| word_b | input | W | Result of instance B |
| word_c | input | W | Result of instance C (used in triplex only) |
| sys_out | output | W | Validated or voted system output |
| out_valid | output | 1 | sys_out is validated |
| fault_alert | output | 1 | Disagreement seen among the instances |
| inc_a | output | W | Score increment for instance A |
| inc_b | output | W | Score increment for instance B |
| inc_c | output | W | Score increment for instance C |

## Verification
The embedded assertions check several rules on every cycle:
- a result never appears without a strobe one cycle earlier;
- a duplex alert never comes with a validated output;
- duplex increments are symmetric, and instance C is not charged in duplex;
- an agreeing result carries zero increments;
- a Hamming score never exceeds the word width.

Only the directed scenarios can confirm the actual values. These are the voted word, the exact Hamming counts and arithmetic differences including the all-ones extreme, the validity of a vote with all three words distinct, and that sys_out holds its value through idle cycles.

// File: rtl/dscore_pkg.sv
// Package: shared encodings for the discrepancy scoring unit.
// Assumes: mode and metric selects are single bits at the top-level ports.
package dscore_pkg;
    typedef enum logic {
        MODE_DUPLEX  = 1'b0,
        MODE_TRIPLEX = 1'b1
    } vote_mode_e;

    typedef enum logic {
        MET_HAMMING = 1'b0,
        MET_WEIGHT  = 1'b1
    } metric_e;

    localparam int unsigned LANES = 3;
endpackage

// File: rtl/dscore_metric.sv
// Module: dscore_metric
// Computes the distance between two words under a selectable metric:
// the population count of their XOR, or their absolute unsigned difference.
// Assumes: SW >= W, so that both metrics fit without truncation.
module dscore_metric
    import dscore_pkg::*;
#(
    parameter int unsigned W  = 32,
    parameter int unsigned SW = W
) (
    input  logic [W-1:0]  lhs,
    input  logic [W-1:0]  rhs,
    input  logic          sel,
    output logic [SW-1:0] score
);
    localparam int unsigned CW = $clog2(W + 1);

    logic [W-1:0]  diff_bits;
    logic [CW-1:0] ham_cnt;
    logic [W-1:0]  abs_diff;

    // Count the bit positions where the operands disagree.
    always_comb begin
        diff_bits = lhs ^ rhs;
        ham_cnt   = '0;
        for (int i = 0; i < int'(W); i++) begin
            ham_cnt = ham_cnt + CW'(diff_bits[i]);
        end
    end

    // Magnitude of the unsigned difference, larger minus smaller.
    always_comb begin
        if (lhs >= rhs) abs_diff = lhs - rhs;
        else            abs_diff = rhs - lhs;
    end

    // Pick the metric requested for this strobe.
    always_comb begin
        if (metric_e'(sel) == MET_WEIGHT) score = SW'(abs_diff);
        else                              score = SW'(ham_cnt);
    end
endmodule

// File: rtl/dscore_vote.sv
// Module: dscore_vote
// Bitwise two-of-three voter. Also reports whether any pair of the words
// agrees and whether all three agree.
// Assumes: purely combinational; the caller registers the results.
module dscore_vote #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic [W-1:0] in_c,
    output logic [W-1:0] maj,
    output logic         pair_eq,
    output logic         all_eq
);
    logic eq_ab, eq_ac, eq_bc;

    // Per-bit majority, built one slice at a time.
    for (genvar g = 0; g < int'(W); g++) begin : g_bit
        always_comb begin
            maj[g] = (in_a[g] & in_b[g]) | (in_a[g] & in_c[g]) | (in_b[g] & in_c[g]);
        end
    end

    // Whole-word agreement between each pair.
    always_comb begin
        eq_ab   = (in_a == in_b);
        eq_ac   = (in_a == in_c);
        eq_bc   = (in_b == in_c);
        pair_eq = eq_ab | eq_ac | eq_bc;
        all_eq  = eq_ab & eq_bc;
    end
endmodule

// File: rtl/dscore_unit.sv
// Module: dscore_unit (top)
// Compares the results of two (duplex) or three (triplex) redundant logic
// instances, drives a validated or voted output, raises a fault alert, and
// issues per-instance discrepancy score increments. All outputs are
// registered and appear one cycle after in_valid.
// Assumes: the caller holds the accumulated scores and performs any
// replacement of instances; word_c is ignored in duplex mode.
module dscore_unit
    import dscore_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         mode,
    input  logic         metric_sel,
    input  logic [W-1:0] word_a,
    input  logic [W-1:0] word_b,
    input  logic [W-1:0] word_c,
    output logic [W-1:0] sys_out,
    output logic         out_valid,
    output logic         fault_alert,
    output logic [W-1:0] inc_a,
    output logic [W-1:0] inc_b,
    output logic [W-1:0] inc_c
);
    localparam int unsigned SW = W;
    localparam int unsigned CW = $clog2(W + 1);

    logic [W-1:0]  maj;
    logic          pair_eq, all_eq;
    logic [W-1:0]  own_w  [LANES];
    logic [W-1:0]  ref_w  [LANES];
    logic [SW-1:0] lane_sc[LANES];

    logic [W-1:0]  nxt_out;
    logic          nxt_valid, nxt_fault;
    logic [SW-1:0] nxt_inc[LANES];
    logic          is_tri;

    dscore_vote #(.W(W)) u_vote (
        .in_a   (word_a),
        .in_b   (word_b),
        .in_c   (word_c),
        .maj    (maj),
        .pair_eq(pair_eq),
        .all_eq (all_eq)
    );

    // Gather the instance words into lane order.
    always_comb begin
        own_w[0] = word_a;
        own_w[1] = word_b;
        own_w[2] = word_c;
        is_tri   = (vote_mode_e'(mode) == MODE_TRIPLEX);
    end

    // Each lane scores its own word against a reference: the vote in
    // triplex mode, the partner word in duplex mode (lane C against itself).
    for (genvar l = 0; l < int'(LANES); l++) begin : g_lane
        always_comb begin
            if (is_tri)      ref_w[l] = maj;
            else if (l == 0) ref_w[l] = word_b;
            else if (l == 1) ref_w[l] = word_a;
            else             ref_w[l] = own_w[l];
        end

        dscore_metric #(.W(W), .SW(SW)) u_metric (
            .lhs  (own_w[l]),
            .rhs  (ref_w[l]),
            .sel  (metric_sel),
            .score(lane_sc[l])
        );
    end

    // Form the next output, validity, alert and increments for the mode.
    always_comb begin
        if (is_tri) begin
            nxt_out   = maj;
            nxt_valid = pair_eq;
            nxt_fault = ~all_eq;
        end else begin
            nxt_valid = (word_a == word_b);
            nxt_fault = ~nxt_valid;
            nxt_out   = nxt_valid ? word_a : '0;
        end
        for (int l = 0; l < int'(LANES); l++) begin
            nxt_inc[l] = lane_sc[l];
        end
    end

    // Output register: load on a strobe, pulse flags clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sys_out     <= '0;
            out_valid   <= 1'b0;
            fault_alert <= 1'b0;
            inc_a       <= '0;
            inc_b       <= '0;
            inc_c       <= '0;
        end else if (in_valid) begin
            sys_out     <= nxt_out;
            out_valid   <= nxt_valid;
            fault_alert <= nxt_fault;
            inc_a       <= W'(nxt_inc[0]);
            inc_b       <= W'(nxt_inc[1]);
            inc_c       <= W'(nxt_inc[2]);
        end else begin
            out_valid   <= 1'b0;
            fault_alert <= 1'b0;
            inc_a       <= '0;
            inc_b       <= '0;
            inc_c       <= '0;
        end
    end

    AST_NO_RESULT_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid || fault_alert) |-> $past(in_valid)); // R8

    AST_DUPLEX_ALERT_BLOCKS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid) && !$past(mode) && fault_alert) |-> !out_valid); // R2

    AST_DUPLEX_SYMMETRIC: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid) && !$past(mode)) |-> (inc_a == inc_b && inc_c == '0)); // R2

    AST_AGREE_NO_CHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !fault_alert) |-> (inc_a == '0 && inc_b == '0 && inc_c == '0)); // R1

    AST_HAMMING_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid) && !$past(metric_sel)) |->
        (inc_a <= W'(CW'(W)) && inc_b <= W'(CW'(W)) && inc_c <= W'(CW'(W)))); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> ($stable(sys_out) && inc_a == '0 && inc_b == '0 && inc_c == '0)); // R8
endmodule

// File: tb/sim_dscore_unit.sv
module sim_dscore_unit;
    localparam int unsigned W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         mode = 1'b0;
    logic         metric_sel = 1'b0;
    logic [W-1:0] word_a = '0, word_b = '0, word_c = '0;
    logic [W-1:0] sys_out, inc_a, inc_b, inc_c;
    logic         out_valid, fault_alert;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dscore_unit #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .metric_sel(metric_sel), .word_a(word_a), .word_b(word_b), .word_c(word_c),
        .sys_out(sys_out), .out_valid(out_valid), .fault_alert(fault_alert),
        .inc_a(inc_a), .inc_b(inc_b), .inc_c(inc_c)
    );

    function automatic logic [W-1:0] ref_ham(logic [W-1:0] x, logic [W-1:0] y);
        logic [W-1:0] n = '0;
        for (int i = 0; i < int'(W); i++) if (x[i] != y[i]) n++;
        return n;
    endfunction

    function automatic logic [W-1:0] ref_abs(logic [W-1:0] x, logic [W-1:0] y);
        return (x > y) ? x - y : y - x;
    endfunction

    function automatic logic [W-1:0] ref_metric(logic s, logic [W-1:0] x, logic [W-1:0] y);
        return s ? ref_abs(x, y) : ref_ham(x, y);
    endfunction

    function automatic logic [W-1:0] ref_vote(logic [W-1:0] x, logic [W-1:0] y, logic [W-1:0] z);
        logic [W-1:0] v;
        for (int i = 0; i < int'(W); i++) v[i] = (int'(x[i]) + int'(y[i]) + int'(z[i])) >= 2;
        return v;
    endfunction

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Strobe one vector and sample one cycle later, away from the edge.
    task automatic strobe(logic m, logic s, logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
        @(negedge clk);
        in_valid = 1'b1; mode = m; metric_sel = s;
        word_a = a; word_b = b; word_c = c;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R9 sys_out", sys_out, '0);
        chk("R9 out_valid", W'(out_valid), '0);
        chk("R9 fault_alert", W'(fault_alert), '0);
        chk("R9 inc_a", inc_a, '0);
        chk("R9 inc_c", inc_c, '0);
    endtask

    task automatic t_duplex_match(logic [W-1:0] v, logic [W-1:0] junk_c);
        strobe(1'b0, 1'b1, v, v, junk_c);
        chk("R1 out_valid", W'(out_valid), 1);
        chk("R1 sys_out", sys_out, v);
        chk("R1 fault_alert", W'(fault_alert), 0);
        chk("R1 inc_a", inc_a, '0);
        chk("R1 inc_c", inc_c, '0);
    endtask

    task automatic t_duplex_miss(logic s, logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
        logic [W-1:0] e = ref_metric(s, a, b);
        strobe(1'b0, s, a, b, c);
        chk("R2 fault_alert", W'(fault_alert), 1);
        chk("R2 out_valid", W'(out_valid), 0);
        chk("R2 sys_out", sys_out, '0);
        chk(s ? "R2 R7 inc_a" : "R2 R6 inc_a", inc_a, e);
        chk("R2 inc_b", inc_b, e);
        chk("R2 inc_c", inc_c, '0);
    endtask

    task automatic t_triplex(logic s, logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
        logic [W-1:0] v = ref_vote(a, b, c);
        logic pv = (a == b) || (a == c) || (b == c);
        logic fa = !((a == b) && (b == c));
        strobe(1'b1, s, a, b, c);
        chk("R3 sys_out", sys_out, v);
        chk("R4 out_valid", W'(out_valid), W'(pv));
        chk("R4 fault_alert", W'(fault_alert), W'(fa));
        chk("R5 inc_a", inc_a, ref_metric(s, a, v));
        chk("R5 inc_b", inc_b, ref_metric(s, b, v));
        chk("R5 inc_c", inc_c, ref_metric(s, c, v));
    endtask

    task automatic t_idle;
        logic [W-1:0] held;
        strobe(1'b0, 1'b0, 32'h1234_5678, 32'h1234_5678, '0);
        held = sys_out;
        @(negedge clk);
        chk("R8 out_valid idle", W'(out_valid), 0);
        chk("R8 fault_alert idle", W'(fault_alert), 0);
        chk("R8 sys_out held", sys_out, held);
        chk("R8 inc_a idle", inc_a, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_duplex_match(32'hCAFE_F00D, 32'hDEAD_BEEF);
        t_duplex_miss(1'b0, 32'hFFFF_0000, 32'h0000_FFFF, 32'h5555_5555);
        t_duplex_miss(1'b0, 32'h0000_0001, 32'h0000_0000, '0);
        t_duplex_miss(1'b1, 32'h0000_0005, 32'hFFFF_FFFF, 32'h1);
        t_duplex_miss(1'b1, 32'h0000_0000, 32'hFFFF_FFFF, '0);
        t_duplex_miss(1'b1, 32'h0000_0100, 32'h0000_00FF, '0);
        t_triplex(1'b0, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 32'hA5A5_A5A5);
        t_triplex(1'b0, 32'h0F0F_0F0F, 32'h0F0F_0F0F, 32'hF0F0_0F0F);
        t_triplex(1'b1, 32'h0000_0010, 32'h0000_0010, 32'h8000_0000);
        t_triplex(1'b0, 32'h0000_00FF, 32'h0000_0F0F, 32'h0000_3333);
        t_triplex(1'b1, 32'hFFFF_0000, 32'h00FF_FF00, 32'h0000_FFFF);
        t_idle();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        t_reset();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule